// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority and Vector Unit

This unit is the interrupt front end of a peripheral that shares one CPU interrupt line with other peripherals through a serial priority chain. Each peripheral has a chain-enable input from the device above it and a chain-enable output to the device below it. A device that is requesting or serving an interrupt holds its enable output low, so devices further down the chain stay quiet. Inside the unit, up to `NUM_SRC` request sources are ranked by index, and source 0 has the highest priority.

The CPU bus is modelled as signals that are sampled on the system clock. A cycle with `m1` high and `iorq` low is an opcode fetch. A cycle with `m1` and `iorq` both high is an interrupt acknowledge. During an acknowledge, the unit returns the programmed vector of its highest-priority pending source, and that source moves to the in-service state. The unit also watches the opcode fetches for the two-byte return sequence 0xED then 0x4D. When the sequence arrives, the unit ends the service of its in-service source. No separate completion wire is needed. While the first byte of that sequence is held, pending requests that have not yet been acknowledged stop blocking the chain. This lets the device that is being served see its enable input high.

Top module: `intr_chain_unit`

## Requirements
- R1: After reset, no source is pending or in service, `intReq` is low, `enOut` equals `enIn`, and every vector register reads 0x00.
- R2: A one-cycle pulse on `srcReq[i]` marks source i pending from the next cycle. `intReq` is high exactly when some source is pending, `enIn` is high, and no source is in service.
- R3: `enOut` is low whenever `enIn` is low or any source is in service. Outside the return-prefix window, `enOut` is also low while any source is pending. This holds in the same cycle in which an acknowledge arrives.
- R4: After a fetch of 0xED and until the next fetch, pending sources no longer pull `enOut` low. In-service sources still do.
- R5: An acknowledge cycle (`m1`=1, `iorq`=1) is accepted when `enIn` is high, a source is pending, and none is in service. In that cycle `vecDrive` is 1 and `vecOut` carries the vector of the chosen source. From the next cycle that source is in service and no longer pending. When no acknowledge is accepted, `vecOut` is 0x00.
- R6: When several sources are pending, the acknowledge chooses the lowest index. Source 0 has the highest priority.
- R7: An acknowledge cycle with `enIn` low, or with a source already in service, is not accepted. `vecDrive` stays 0 and no pending or in-service state changes.
- R8: A fetch of 0x4D that directly follows a fetch of 0xED, with `enIn` high, clears the in-service flag of the lowest-index in-service source.
- R9: A fetch of any byte other than 0x4D after 0xED cancels the prefix, and in-service flags stay unchanged. A fetch of 0xED re-arms the prefix.
- R10: The return sequence has no effect while `enIn` is low at the 0x4D fetch.
- R11: When `vecWrEn` is high, `vecWrData` is written into the vector register of source `vecWrSel`. An acknowledge in a later cycle returns the new value.
- R12: Cycles with `m1` low are neither fetches nor acknowledges. They neither cancel the prefix nor produce `vecDrive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enIn | input | 1 | Chain enable from the higher-priority device |
| m1 | input | 1 | Machine-cycle-one indication from the CPU |
| iorq | input | 1 | I/O request from the CPU; together with `m1` it marks an acknowledge |
| busData | input | 8 | Data bus value observed during fetches |
| srcReq | input | NUM_SRC | Per-source request pulses |
| vecWrEn | input | 1 | Vector register write strobe |
| vecWrSel | input | SEL_W | Index of the vector register to write |
| vecWrData | input | VEC_W | Vector value to write |
| enOut | output | 1 | Chain enable to the lower-priority device |
| intReq | output | 1 | Interrupt request toward the CPU, active high |
| vecDrive | output | 1 | High while the unit returns a vector |
| vecOut | output | VEC_W | Returned vector; 0x00 when not driving |

## Verification
The assertions assume that `m1` and `iorq` describe only fetch, acknowledge or idle cycles. They also assume that `enIn` from upstream can change in any cycle, including during an acknowledge. The stimulus drives every bus cycle for exactly one clock and returns the bus to idle between cycles, except where idle gaps are placed on purpose inside the return sequence. Request pulses are kept apart from the acknowledges of the same source, so that the pending state each check expects is unambiguous. An acknowledge with `enIn` low and an acknowledge during service are both issued on purpose, to exercise the rejection paths.

// File: rtl/intr_chain_pkg.sv
package intr_chain_pkg;

  localparam int BUS_W = 8;
  localparam logic [BUS_W-1:0] PREFIX_BYTE = 8'hED;
  localparam logic [BUS_W-1:0] RETURN_BYTE = 8'h4D;

  // strobes from control to datapath
  typedef struct packed {
    logic ackStb;   // accepted acknowledge this cycle
    logic relStb;   // return sequence completed this cycle
    logic wrStb;    // vector register write
  } chainStb_t;

endpackage

// File: rtl/intr_chain_dp.sv
module intr_chain_dp
  import intr_chain_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int VEC_W   = 8,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  chainStb_t          stb,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [SEL_W-1:0]   vecWrSel,
  input  logic [VEC_W-1:0]   vecWrData,
  output logic               anyPending,
  output logic               anyInService,
  output logic [VEC_W-1:0]   vecOut
);

  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] inService;
  logic [NUM_SRC-1:0] grantOh;
  logic [NUM_SRC-1:0] relOh;
  logic [VEC_W-1:0]   vecReg [NUM_SRC];

  // lowest index wins for both grant and release
  always_comb begin
    logic seenP;
    logic seenS;
    grantOh = '0;
    relOh   = '0;
    seenP   = 1'b0;
    seenS   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && !seenP) begin
        grantOh[i] = 1'b1;
        seenP      = 1'b1;
      end
      if (inService[i] && !seenS) begin
        relOh[i] = 1'b1;
        seenS    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      inService <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        pending[i]   <= (pending[i] & ~(stb.ackStb & grantOh[i])) | srcReq[i];
        inService[i] <= (inService[i] | (stb.ackStb & grantOh[i]))
                        & ~(stb.relStb & relOh[i]);
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gVec
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          vecReg[g] <= '0;
        end else if (stb.wrStb && (vecWrSel == SEL_W'(g))) begin
          vecReg[g] <= vecWrData;
        end
      end
    end
  endgenerate

  always_comb begin
    vecOut = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (stb.ackStb && grantOh[i]) vecOut = vecOut | vecReg[i];
    end
  end

  assign anyPending   = |pending;
  assign anyInService = |inService;

endmodule

// File: rtl/intr_chain_ctrl.sv
module intr_chain_ctrl
  import intr_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enIn,
  input  logic             m1,
  input  logic             iorq,
  input  logic [BUS_W-1:0] busData,
  input  logic             vecWrEn,
  input  logic             anyPending,
  input  logic             anyInService,
  output chainStb_t        stb,
  output logic             intReq,
  output logic             enOut,
  output logic             vecDrive
);

  logic fetchCyc;
  logic ackCyc;
  logic prefixSeen;

  assign fetchCyc = m1 & ~iorq;
  assign ackCyc   = m1 & iorq;

  // every fetch re-evaluates the prefix; other cycles leave it alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prefixSeen <= 1'b0;
    end else if (fetchCyc) begin
      prefixSeen <= (busData == PREFIX_BYTE);
    end
  end

  always_comb begin
    stb.ackStb = ackCyc & enIn & anyPending & ~anyInService;
    stb.relStb = fetchCyc & prefixSeen & (busData == RETURN_BYTE)
                 & enIn & anyInService;
    stb.wrStb  = vecWrEn;
  end

  assign intReq   = anyPending & enIn & ~anyInService;
  assign enOut    = enIn & ~anyInService & (~anyPending | prefixSeen);
  assign vecDrive = stb.ackStb;

endmodule

// File: rtl/intr_chain_unit.sv
module intr_chain_unit
  import intr_chain_pkg::*;
#(
  parameter  int NUM_SRC = 2,
  parameter  int VEC_W   = 8,
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enIn,
  input  logic               m1,
  input  logic               iorq,
  input  logic [BUS_W-1:0]   busData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               vecWrEn,
  input  logic [SEL_W-1:0]   vecWrSel,
  input  logic [VEC_W-1:0]   vecWrData,
  output logic               enOut,
  output logic               intReq,
  output logic               vecDrive,
  output logic [VEC_W-1:0]   vecOut
);

  chainStb_t stb;
  logic      anyPending;
  logic      anyInService;

  intr_chain_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .enIn         (enIn),
    .m1           (m1),
    .iorq         (iorq),
    .busData      (busData),
    .vecWrEn      (vecWrEn),
    .anyPending   (anyPending),
    .anyInService (anyInService),
    .stb          (stb),
    .intReq       (intReq),
    .enOut        (enOut),
    .vecDrive     (vecDrive)
  );

  intr_chain_dp #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .SEL_W   (SEL_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .srcReq       (srcReq),
    .vecWrSel     (vecWrSel),
    .vecWrData    (vecWrData),
    .anyPending   (anyPending),
    .anyInService (anyInService),
    .vecOut       (vecOut)
  );

endmodule

// File: rtl/intr_chain_chk.sv
module intr_chain_chk (
  input logic clk,
  input logic rstN,
  input logic enIn,
  input logic m1,
  input logic iorq,
  input logic enOut,
  input logic intReq,
  input logic vecDrive
);

  // R2
  intreq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> enIn);

  // R3
  enout_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    enOut |-> enIn);

  // R5
  ack_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecDrive |-> (m1 && iorq && enIn));

  // R5
  ack_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecDrive |=> (!intReq && !enOut));

  // R7
  ack_needs_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (m1 && iorq && !enIn) |-> !vecDrive);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !m1 |-> !vecDrive);

endmodule

bind intr_chain_unit intr_chain_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .enIn     (enIn),
  .m1       (m1),
  .iorq     (iorq),
  .enOut    (enOut),
  .intReq   (intReq),
  .vecDrive (vecDrive)
);

// File: tb/tb_intr_chain_unit.sv
`timescale 1ns/1ps
module tb_intr_chain_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enIn = 1'b1;
  logic       m1 = 1'b0;
  logic       iorq = 1'b0;
  logic [7:0] busData = 8'h00;
  logic [1:0] srcReq = 2'b00;
  logic       vecWrEn = 1'b0;
  logic       vecWrSel = 1'b0;
  logic [7:0] vecWrData = 8'h00;
  logic       enOut, intReq, vecDrive;
  logic [7:0] vecOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  intr_chain_unit dut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .m1(m1), .iorq(iorq),
    .busData(busData), .srcReq(srcReq), .vecWrEn(vecWrEn),
    .vecWrSel(vecWrSel), .vecWrData(vecWrData), .enOut(enOut),
    .intReq(intReq), .vecDrive(vecDrive), .vecOut(vecOut)
  );

  // behavioural reference model
  bit  mPend[2];
  bit  mSvc[2];
  int  mVec[2];
  bit  mPfx;

  function automatic bit anyP(); return mPend[0] | mPend[1]; endfunction
  function automatic bit anyS(); return mSvc[0] | mSvc[1]; endfunction
  function automatic bit ackOk();
    return m1 && iorq && enIn && anyP() && !anyS();
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend = '{0, 0}; mSvc = '{0, 0}; mVec = '{0, 0}; mPfx = 0;
    end else begin
      bit ack;
      int hi;
      bit oldP[2];
      ack  = ackOk();
      hi   = mPend[0] ? 0 : 1;
      oldP = mPend;
      if (m1 && !iorq) begin
        if (mPfx && busData == 8'h4D && enIn && anyS()) begin
          if (mSvc[0]) mSvc[0] = 0; else mSvc[1] = 0;
        end
        mPfx = (busData == 8'hED);
      end
      if (ack) begin
        oldP[hi] = 0;
        mSvc[hi] = 1;
      end
      mPend[0] = oldP[0] | srcReq[0];
      mPend[1] = oldP[1] | srcReq[1];
      if (vecWrEn) mVec[vecWrSel] = vecWrData;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(curReq, "intReq", intReq, anyP() && enIn && !anyS());
      chk(curReq, "enOut", enOut, enIn && !anyS() && (!anyP() || mPfx));
      chk(curReq, "vecDrive", vecDrive, ackOk());
      chk(curReq, "vecOut", vecOut, ackOk() ? mVec[mPend[0] ? 0 : 1] : 0);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    m1 = 0; iorq = 0; busData = 8'h00; srcReq = 2'b00; vecWrEn = 0;
  endtask

  task automatic fetch(input logic [7:0] d);
    m1 = 1; iorq = 0; busData = d; tick();
  endtask

  task automatic req(input logic [1:0] r);
    srcReq = r; tick();
  endtask

  task automatic wrVec(input logic s, input logic [7:0] d);
    vecWrEn = 1; vecWrSel = s; vecWrData = d; tick();
  endtask

  // acknowledge with explicit checks in the cycle
  task automatic ack(string tag, input bit expDrv, input logic [7:0] expVec);
    m1 = 1; iorq = 1;
    @(negedge clk);
    chk(tag, "ack vecDrive", vecDrive, expDrv);
    chk(tag, "ack vecOut", vecOut, expVec);
    tick();
  endtask

  task automatic look(string tag, input bit expInt, input bit expEn);
    @(negedge clk);
    chk(tag, "intReq", intReq, expInt);
    chk(tag, "enOut", enOut, expEn);
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    curReq = "R1";
    look("R1", 0, 1);
    enIn = 0; look("R1", 0, 0); enIn = 1;
    req(2'b10);
    ack("R1", 1, 8'h00);                 // vector reset to 0x00
    fetch(8'hED); fetch(8'h4D);
    look("R8", 0, 1);

    // R11 vector writes
    curReq = "R11";
    wrVec(0, 8'hA0); wrVec(1, 8'h3C);

    // R2 request gating by enIn
    curReq = "R2";
    enIn = 0; req(2'b10);
    look("R2", 0, 0);
    enIn = 1;
    look("R2", 1, 0);                    // R3 pending blocks chain

    // R5 acknowledge returns source 1 vector
    curReq = "R5";
    ack("R11", 1, 8'h3C);
    look("R5", 0, 0);

    // R7 rejected acknowledges
    curReq = "R7";
    req(2'b01);
    ack("R7", 0, 8'h00);                 // already in service
    look("R7", 0, 0);

    // R9 cancel, R10 enIn low, R12 idle gap
    curReq = "R9";
    fetch(8'hED); fetch(8'h00); fetch(8'h4D);
    look("R9", 0, 0);
    fetch(8'hED); fetch(8'hED); fetch(8'h12);
    look("R9", 0, 0);
    curReq = "R10";
    fetch(8'hED); enIn = 0; fetch(8'h4D); enIn = 1;
    look("R10", 0, 0);
    curReq = "R12";
    fetch(8'hED);
    @(posedge clk); #1; @(posedge clk); #1;
    fetch(8'h4D);                        // releases source 1
    curReq = "R12";
    look("R12", 1, 0);                   // source 0 still pending

    // R6 / R7: enIn low ack rejected, then priority
    curReq = "R7";
    enIn = 0; ack("R7", 0, 8'h00); enIn = 1;
    curReq = "R6";
    req(2'b10);                          // both pending now
    ack("R6", 1, 8'hA0);
    fetch(8'hED); fetch(8'h4D);
    ack("R6", 1, 8'h3C);
    fetch(8'hED); fetch(8'h4D);
    look("R8", 0, 1);

    // R4 prefix window releases pending block
    curReq = "R4";
    req(2'b01);
    look("R4", 1, 0);
    fetch(8'hED);
    look("R4", 1, 1);
    fetch(8'h00);
    look("R4", 1, 0);
    ack("R4", 1, 8'hA0);
    fetch(8'hED);
    look("R4", 0, 0);                    // in service still blocks
    fetch(8'h4D);
    look("R8", 0, 1);

    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule